// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the address of one memory operand for an x86-style processor. It supports 16-, 32- and 64-bit operand modes. Each request carries a base register and an index register, with their codes, values and enables, a scale code and a signed 32-bit displacement. It also carries an optional segment override, the segment selector value (used in 16-bit mode), a segment base (used in 32- and 64-bit mode), the instruction pointer and an instruction-relative flag.

The block returns the effective offset, the linear address and the segment code it applied. All three modes share one three-input adder. The mode only decides how the index is shifted, where the sum wraps and how the segment contribution is formed. An illegal register or segment choice produces a one-cycle error pulse instead of a result.

Requests enter through a valid/ready handshake. A result appears in the cycle after acceptance and is held until the consumer takes it.

Top module: `ea_linear_gen`

## Requirements
- R1: In mode 0 (16-bit) the offset is (base value if enabled) + (index value if enabled) + sign-extended displacement, kept to its low 16 bits and zero-extended. The scale code has no effect in this mode.
- R2: In mode 0 the linear address is (selector shifted left 4) + offset, kept to 20 bits. Only segment codes 0 to 3 are legal in this mode.
- R3: In mode 1 (32-bit) the offset is base + (index shifted left by scale code 0..3) + sign-extended displacement, modulo 2^32. The linear address is segment base + offset, modulo 2^32.
- R4: In mode 2 (64-bit) base and index may be any register code 0..15, with the same scaling and a 64-bit wrap. The segment base is added only for segment code 4 or 5 (FS, GS). Every other segment contributes zero.
- R5: In mode 2 with the relative flag set, the offset is the instruction pointer + sign-extended displacement. The base and index inputs are ignored.
- R6: Segment codes are 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS. With an override the given code is used. Otherwise the code is SS when an enabled base is register code 4 or 5 (and the relative form is not in use), and DS in all other cases.
- R7: An illegal request gives err high for exactly one cycle and leaves out_valid low. Illegal requests are:
  - mode 3;
  - in mode 0, a base other than code 3 (BX) or 5 (BP), or an index other than code 6 (SI) or 7 (DI);
  - in mode 1, a register code above 7, or index code 4;
  - segment code 6 or 7 in any mode;
  - the relative flag outside mode 2.
- R8: in_ready is high when no result is pending or out_ready is high. An accepted legal request appears on out_valid one cycle later. A pending result stays unchanged while out_ready is low.
- R9: A synchronous reset clears out_valid and err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| mode | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = illegal |
| base_en | input | 1 | Base register used |
| base_sel | input | 4 | Base register code |
| base_val | input | 64 | Base register value |
| idx_en | input | 1 | Index register used |
| idx_sel | input | 4 | Index register code |
| idx_val | input | 64 | Index register value |
| scale | input | 2 | Index shift amount |
| disp | input | 32 | Signed displacement |
| seg_ovr | input | 1 | Segment override present |
| seg_code | input | 3 | Override segment code |
| seg_selector | input | 16 | Segment value for 16-bit mode |
| seg_base | input | 64 | Segment base for 32/64-bit mode |
| ip | input | 64 | Instruction pointer |
| rip_rel | input | 1 | Instruction-relative form |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be consumed |
| eff_off | output | 64 | Effective offset |
| lin_addr | output | 64 | Linear address |
| seg_used | output | 3 | Segment code applied |
| err | output | 1 | Illegal request pulse |

## Verification
The bench targets the wrap points:
- a 16-bit sum crossing 64 KiB and a segment-plus-offset crossing 1 MiB, which a design without the masks would report as 17- or 21-bit values;
- 32-bit sums whose register values carry garbage in their upper half, which would leak into the result.

Negative displacements in the 64-bit relative form catch a design that zero-extends instead of sign-extending. A GS base that overflows 2^64 and an SS base that must contribute zero catch wrong segment gating. The rejection cases are checked one by one: the stack pointer as a 32-bit index, a 16-bit accumulator base, FS in 16-bit mode and the relative flag in 32-bit mode. Each of these would otherwise produce a valid but meaningless result. A stalled consumer checks that a pending result is held rather than overwritten.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    AM_16   = 2'd0,
    AM_32   = 2'd1,
    AM_64   = 2'd2,
    AM_RSVD = 2'd3
  } am_e;

  localparam int SEG_W = 3;
  localparam logic [SEG_W-1:0] SG_ES = 3'd0;
  localparam logic [SEG_W-1:0] SG_CS = 3'd1;
  localparam logic [SEG_W-1:0] SG_SS = 3'd2;
  localparam logic [SEG_W-1:0] SG_DS = 3'd3;
  localparam logic [SEG_W-1:0] SG_FS = 3'd4;
  localparam logic [SEG_W-1:0] SG_GS = 3'd5;

  localparam int GR_BX = 3;
  localparam int GR_SP = 4;
  localparam int GR_BP = 5;
  localparam int GR_SI = 6;
  localparam int GR_DI = 7;
  localparam int GR_LEGACY_CNT = 8;
endpackage

// File: rtl/ea_rule_chk.sv
module ea_rule_chk
  import ea_pkg::*;
#(
  parameter int RSEL_W = 4
) (
  input  am_e               mode,
  input  logic              base_en,
  input  logic [RSEL_W-1:0] base_sel,
  input  logic              idx_en,
  input  logic [RSEL_W-1:0] idx_sel,
  input  logic              rip_rel,
  input  logic              seg_ovr,
  input  logic [SEG_W-1:0]  seg_code,
  output logic              illegal,
  output logic [SEG_W-1:0]  seg_eff
);
  localparam logic [RSEL_W-1:0] BX = RSEL_W'(GR_BX);
  localparam logic [RSEL_W-1:0] BP = RSEL_W'(GR_BP);
  localparam logic [RSEL_W-1:0] SP = RSEL_W'(GR_SP);
  localparam logic [RSEL_W-1:0] SI = RSEL_W'(GR_SI);
  localparam logic [RSEL_W-1:0] DI = RSEL_W'(GR_DI);
  localparam logic [RSEL_W-1:0] LEG_LIM = RSEL_W'(GR_LEGACY_CNT);

  logic bad_seg, stack_base, rel_form;

  assign bad_seg    = seg_ovr && (seg_code > SG_GS);
  assign rel_form   = rip_rel && (mode == AM_64);
  assign stack_base = base_en && !rel_form && (base_sel == SP || base_sel == BP);
  assign seg_eff    = seg_ovr ? seg_code : (stack_base ? SG_SS : SG_DS);

  always_comb begin
    illegal = bad_seg;
    unique case (mode)
      AM_16: begin
        if (base_en && !(base_sel == BX || base_sel == BP)) illegal = 1'b1;
        if (idx_en && !(idx_sel == SI || idx_sel == DI))    illegal = 1'b1;
        if (seg_ovr && seg_code > SG_DS)                    illegal = 1'b1;
        if (rip_rel)                                        illegal = 1'b1;
      end
      AM_32: begin
        if (base_en && base_sel >= LEG_LIM)                      illegal = 1'b1;
        if (idx_en && (idx_sel >= LEG_LIM || idx_sel == SP))     illegal = 1'b1;
        if (rip_rel)                                             illegal = 1'b1;
      end
      AM_64:   ;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
  import ea_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 32,
  parameter int W16    = 16,
  parameter int W32    = 32
) (
  input  am_e             mode,
  input  logic            rel_form,
  input  logic            base_en,
  input  logic [XLEN-1:0] base_val,
  input  logic            idx_en,
  input  logic [XLEN-1:0] idx_val,
  input  logic [1:0]      scale,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0] ip,
  output logic [XLEN-1:0] off
);
  localparam logic [XLEN-1:0] MASK16 = {{(XLEN-W16){1'b0}}, {W16{1'b1}}};
  localparam logic [XLEN-1:0] MASK32 = {{(XLEN-W32){1'b0}}, {W32{1'b1}}};

  logic [XLEN-1:0] disp_x, base_t, idx_t, raw;
  logic [1:0]      sh;

  assign disp_x = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
  assign sh     = (mode == AM_16) ? 2'd0 : scale;

  always_comb begin
    base_t = rel_form ? ip : (base_en ? base_val : '0);
    idx_t  = (!rel_form && idx_en) ? (idx_val << sh) : '0;
    raw    = base_t + idx_t + disp_x;
    unique case (mode)
      AM_16:   off = raw & MASK16;
      AM_32:   off = raw & MASK32;
      default: off = raw;
    endcase
  end
endmodule

// File: rtl/ea_linear_map.sv
module ea_linear_map
  import ea_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int SEL_W = 16,
  parameter int W16   = 16,
  parameter int W32   = 32
) (
  input  am_e              mode,
  input  logic [SEG_W-1:0] seg_eff,
  input  logic [SEL_W-1:0] selector,
  input  logic [XLEN-1:0]  seg_base,
  input  logic [XLEN-1:0]  off,
  output logic [XLEN-1:0]  lin
);
  localparam int LIN16_W = SEL_W + 4;

  logic [LIN16_W-1:0] real_sum;
  logic [W32-1:0]     prot_sum;
  logic               fsgs;

  assign real_sum = {selector, 4'b0000} + LIN16_W'(off[W16-1:0]);
  assign prot_sum = seg_base[W32-1:0] + off[W32-1:0];
  assign fsgs     = (seg_eff == SG_FS) || (seg_eff == SG_GS);

  always_comb begin
    unique case (mode)
      AM_16:   lin = XLEN'(real_sum);
      AM_32:   lin = XLEN'(prot_sum);
      default: lin = off + (fsgs ? seg_base : '0);
    endcase
  end
endmodule

// File: rtl/ea_linear_gen.sv
module ea_linear_gen
  import ea_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 32,
  parameter int SEL_W  = 16,
  parameter int RSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        mode,
  input  logic              base_en,
  input  logic [RSEL_W-1:0] base_sel,
  input  logic [XLEN-1:0]   base_val,
  input  logic              idx_en,
  input  logic [RSEL_W-1:0] idx_sel,
  input  logic [XLEN-1:0]   idx_val,
  input  logic [1:0]        scale,
  input  logic [DISP_W-1:0] disp,
  input  logic              seg_ovr,
  input  logic [2:0]        seg_code,
  input  logic [SEL_W-1:0]  seg_selector,
  input  logic [XLEN-1:0]   seg_base,
  input  logic [XLEN-1:0]   ip,
  input  logic              rip_rel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   eff_off,
  output logic [XLEN-1:0]   lin_addr,
  output logic [2:0]        seg_used,
  output logic              err
);
  am_e              mode_e;
  logic             illegal, rel_form, take;
  logic [SEG_W-1:0] seg_eff;
  logic [XLEN-1:0]  off_c, lin_c;

  assign mode_e   = am_e'(mode);
  assign rel_form = rip_rel && (mode_e == AM_64);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  ea_rule_chk #(.RSEL_W(RSEL_W)) u_rule (
    .mode     (mode_e),
    .base_en  (base_en),
    .base_sel (base_sel),
    .idx_en   (idx_en),
    .idx_sel  (idx_sel),
    .rip_rel  (rip_rel),
    .seg_ovr  (seg_ovr),
    .seg_code (seg_code),
    .illegal  (illegal),
    .seg_eff  (seg_eff)
  );

  ea_offset_sum #(.XLEN(XLEN), .DISP_W(DISP_W)) u_sum (
    .mode     (mode_e),
    .rel_form (rel_form),
    .base_en  (base_en),
    .base_val (base_val),
    .idx_en   (idx_en),
    .idx_val  (idx_val),
    .scale    (scale),
    .disp     (disp),
    .ip       (ip),
    .off      (off_c)
  );

  ea_linear_map #(.XLEN(XLEN), .SEL_W(SEL_W)) u_map (
    .mode     (mode_e),
    .seg_eff  (seg_eff),
    .selector (seg_selector),
    .seg_base (seg_base),
    .off      (off_c),
    .lin      (lin_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      eff_off   <= '0;
      lin_addr  <= '0;
      seg_used  <= '0;
    end else begin
      err <= take && illegal;
      if (take) begin
        out_valid <= !illegal;
        if (!illegal) begin
          eff_off  <= off_c;
          lin_addr <= lin_c;
          seg_used <= seg_eff;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ea_linear_gen_chk.sv
module ea_linear_gen_chk #(
  parameter int XLEN   = 64,
  parameter int RSEL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        mode,
  input logic              idx_en,
  input logic [RSEL_W-1:0] idx_sel,
  input logic              rip_rel,
  input logic              seg_ovr,
  input logic [2:0]        seg_code,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XLEN-1:0]   eff_off,
  input logic [XLEN-1:0]   lin_addr,
  input logic [2:0]        seg_used,
  input logic              err
);
  logic take;
  assign take = in_valid && in_ready;

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(eff_off) && $stable(lin_addr) && $stable(seg_used)));

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    take |=> (out_valid ^ err));

  p_err_novalid_r7: assert property (@(posedge clk) disable iff (rst)
    err |-> !out_valid);

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !take |=> !err);

  p_esp_index_r7: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'd1 && idx_en && idx_sel == RSEL_W'(4)) |=> err);

  p_rel_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (take && rip_rel && mode != 2'd2) |=> err);

  p_wrap16_r1: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'd0) |=> (err || (eff_off[XLEN-1:16] == '0 && lin_addr[XLEN-1:20] == '0)));

  p_seg16_r2: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'd0) |=> (err || seg_used <= 3'd3));

  p_wrap32_r3: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'd1) |=> (err || (eff_off[XLEN-1:32] == '0 && lin_addr[XLEN-1:32] == '0)));

  p_override_r6: assert property (@(posedge clk) disable iff (rst)
    (take && seg_ovr) |=> (err || seg_used == $past(seg_code)));
endmodule

bind ea_linear_gen ea_linear_gen_chk #(.XLEN(XLEN), .RSEL_W(RSEL_W)) u_chk (.*);

// File: tb/ea_linear_gen_tb.sv
module ea_linear_gen_tb;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, out_valid, out_ready, err;
  logic [1:0]  mode, scale;
  logic        base_en, idx_en, seg_ovr, rip_rel;
  logic [3:0]  base_sel, idx_sel;
  logic [63:0] base_val, idx_val, seg_base, ip, eff_off, lin_addr;
  logic [31:0] disp;
  logic [2:0]  seg_code, seg_used;
  logic [15:0] seg_selector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ea_linear_gen u_dut (.*);

  typedef struct packed {
    logic [1:0]  md;
    logic        ben;
    logic [3:0]  bsel;
    logic [63:0] bval;
    logic        ien;
    logic [3:0]  isel;
    logic [63:0] ival;
    logic [1:0]  sc;
    logic [31:0] dsp;
    logic        ovr;
    logic [2:0]  sg;
    logic [15:0] sel;
    logic [63:0] sbase;
    logic [63:0] ipv;
    logic        rip;
    logic [63:0] xoff;
    logic [63:0] xlin;
    logic [2:0]  xseg;
    logic        xerr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'd0,1'b1,4'd3,64'h1234,1'b1,4'd6,64'h10,2'd3,32'h5,1'b0,3'd0,16'h1000,64'h0,64'h0,1'b0,64'h1249,64'h11249,3'd3,1'b0},
    '{2'd0,1'b1,4'd5,64'hFFF0,1'b1,4'd7,64'h20,2'd0,32'hFFFFFFFF,1'b0,3'd0,16'hF000,64'h0,64'h0,1'b0,64'hF,64'hF000F,3'd2,1'b0},
    '{2'd0,1'b0,4'd0,64'h0,1'b0,4'd0,64'h0,2'd0,32'h0000FFFF,1'b1,3'd0,16'hFFFF,64'h0,64'h0,1'b0,64'hFFFF,64'hFFEF,3'd0,1'b0},
    '{2'd1,1'b1,4'd0,64'hAAAAAAAA_FFFFFFF0,1'b1,4'd1,64'h10,2'd2,32'h8,1'b0,3'd0,16'h0,64'h10000,64'h0,1'b0,64'h38,64'h10038,3'd3,1'b0},
    '{2'd1,1'b1,4'd4,64'h2000,1'b0,4'd0,64'h0,2'd0,32'hFFFFFFFC,1'b0,3'd0,16'h0,64'hFFFFF000,64'h0,1'b0,64'h1FFC,64'hFFC,3'd2,1'b0},
    '{2'd1,1'b1,4'd5,64'h100,1'b1,4'd7,64'h3,2'd3,32'h0,1'b1,3'd4,16'h0,64'h50000000,64'h0,1'b0,64'h118,64'h50000118,3'd4,1'b0},
    '{2'd1,1'b1,4'd0,64'h0,1'b1,4'd4,64'h5,2'd0,32'h0,1'b0,3'd0,16'h0,64'h0,64'h0,1'b0,64'h0,64'h0,3'd0,1'b1},
    '{2'd2,1'b1,4'd9,64'h00007FFF_00000000,1'b1,4'd12,64'h100,2'd1,32'hFFFFFF00,1'b0,3'd0,16'h0,64'hDEAD0000,64'h0,1'b0,64'h00007FFF_00000100,64'h00007FFF_00000100,3'd3,1'b0},
    '{2'd2,1'b1,4'd0,64'h1000,1'b1,4'd4,64'h10,2'd0,32'h4,1'b1,3'd5,16'h0,64'hFFFFFFFF_FFFFF000,64'h0,1'b0,64'h1014,64'h14,3'd5,1'b0},
    '{2'd2,1'b1,4'd0,64'h9999,1'b1,4'd1,64'h77,2'd2,32'h80,1'b0,3'd0,16'h0,64'h1234,64'h00004000_00001000,1'b1,64'h00004000_00001080,64'h00004000_00001080,3'd3,1'b0},
    '{2'd1,1'b0,4'd0,64'h0,1'b0,4'd0,64'h0,2'd0,32'h10,1'b0,3'd0,16'h0,64'h0,64'h100,1'b1,64'h0,64'h0,3'd0,1'b1},
    '{2'd0,1'b1,4'd0,64'h10,1'b0,4'd0,64'h0,2'd0,32'h0,1'b0,3'd0,16'h0,64'h0,64'h0,1'b0,64'h0,64'h0,3'd0,1'b1},
    '{2'd0,1'b0,4'd0,64'h0,1'b0,4'd0,64'h0,2'd0,32'h0,1'b1,3'd4,16'h0,64'h0,64'h0,1'b0,64'h0,64'h0,3'd0,1'b1},
    '{2'd1,1'b1,4'd8,64'h10,1'b0,4'd0,64'h0,2'd0,32'h0,1'b0,3'd0,16'h0,64'h0,64'h0,1'b0,64'h0,64'h0,3'd0,1'b1},
    '{2'd2,1'b0,4'd0,64'h0,1'b0,4'd0,64'h0,2'd0,32'h80000000,1'b1,3'd4,16'h0,64'h100,64'h10000000,1'b1,64'hFFFFFFFF_90000000,64'hFFFFFFFF_90000100,3'd4,1'b0},
    '{2'd3,1'b0,4'd0,64'h0,1'b0,4'd0,64'h0,2'd0,32'h0,1'b0,3'd0,16'h0,64'h0,64'h0,1'b0,64'h0,64'h0,3'd0,1'b1},
    '{2'd0,1'b1,4'd5,64'h100,1'b0,4'd0,64'h0,2'd0,32'h0,1'b1,3'd3,16'h0001,64'h0,64'h0,1'b0,64'h100,64'h110,3'd3,1'b0},
    '{2'd2,1'b1,4'd4,64'h8000,1'b0,4'd0,64'h0,2'd0,32'h10,1'b0,3'd0,16'h0,64'h5555,64'h0,1'b0,64'h8010,64'h8010,3'd2,1'b0}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.xerr)       return "R7";
    if (v.rip)        return "R5";
    if (v.md == 2'd0) return "R1/R2";
    if (v.md == 2'd1) return "R3";
    return "R4";
  endfunction

  task automatic drive(input vec_t v);
    mode = v.md; base_en = v.ben; base_sel = v.bsel; base_val = v.bval;
    idx_en = v.ien; idx_sel = v.isel; idx_val = v.ival; scale = v.sc;
    disp = v.dsp; seg_ovr = v.ovr; seg_code = v.sg; seg_selector = v.sel;
    seg_base = v.sbase; ip = v.ipv; rip_rel = v.rip; in_valid = 1'b1;
  endtask

  task automatic check_vec(input vec_t v);
    string t;
    t = tag_of(v);
    if (v.xerr) begin
      chk(err && !out_valid, t, "err/valid", {62'b0, err, out_valid}, 64'h2);
    end else begin
      chk(out_valid && !err, t, "valid/err", {62'b0, err, out_valid}, 64'h1);
      chk(eff_off == v.xoff, t, "offset", eff_off, v.xoff);
      chk(lin_addr == v.xlin, t, "linear", lin_addr, v.xlin);
      chk(seg_used == v.xseg, "R6", "segment", 64'(seg_used), 64'(v.xseg));
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    drive(VEC[0]); in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(!out_valid, "R9", "out_valid after reset", 64'(out_valid), 64'h0);
    chk(!err, "R9", "err after reset", 64'(err), 64'h0);
    chk(in_ready, "R8", "in_ready idle", 64'(in_ready), 64'h1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(VEC[i]);
    end

    // R7: error is a single-cycle pulse
    drive(VEC[6]);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(err, "R7", "err raised", 64'(err), 64'h1);
    @(posedge clk); @(negedge clk);
    chk(!err && !out_valid, "R7", "err cleared", {62'b0, err, out_valid}, 64'h0);

    // R8: consumed result with no new request drops out_valid
    drive(VEC[0]);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!out_valid, "R8", "valid drops after consume", 64'(out_valid), 64'h0);

    // R8: backpressure holds the result and blocks input
    out_ready = 1'b0;
    drive(VEC[0]);
    @(posedge clk); @(negedge clk);
    drive(VEC[3]);
    chk(!in_ready, "R8", "in_ready low while stalled", 64'(in_ready), 64'h0);
    @(posedge clk); @(negedge clk);
    chk(out_valid, "R8", "valid held", 64'(out_valid), 64'h1);
    chk(eff_off == VEC[0].xoff, "R8", "offset held", eff_off, VEC[0].xoff);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(eff_off == VEC[3].xoff, "R8", "next result after release", eff_off, VEC[3].xoff);
    chk(lin_addr == VEC[3].xlin, "R8", "next linear after release", lin_addr, VEC[3].xlin);

    // R9: reset while a result is pending
    out_ready = 1'b0;
    drive(VEC[1]);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk(!out_valid, "R9", "reset clears pending", 64'(out_valid), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule